// File: doc/BRIEF.md
# Permission-Checking Address Translation Buffer

This block translates 32-bit virtual addresses into physical addresses for 4 KB pages. It holds a small set of translations, and any virtual page may sit in any slot. A lookup compares the virtual page number against every slot at once. Each request returns a hit with the physical address, a miss, or a protection fault. The result appears one cycle after the request is accepted.

Each slot keeps its page numbers, read/write/execute permissions, and use and dirty status. A hit only counts when the access type is allowed by the page. A permitted hit marks the slot as used. A permitted write also marks it dirty. A denied access leaves the status untouched. After a miss, outside logic installs the translation through a refill port. The refill goes into the lowest-numbered free slot, or into the least recently used slot when every slot is valid. When a dirty slot is evicted, the block reports its page numbers for one cycle so that the page can be written back. A flush input drops every translation in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: A permitted hit returns `rsp_res_o` = 0 and `rsp_paddr_o` = {stored physical page, low 12 bits of the request address}. Result codes are 0 = hit, 1 = miss, 2 = fault.
- R2: A translation stored in any of the slots is found by its virtual page number (address bits 31:12), whichever slot holds it.
- R3: A request whose page has no valid slot returns a miss (code 1) with `rsp_paddr_o` = 0. This includes every request after reset or flush.
- R4: The access type is 0 = read, 1 = write, 2 = execute. Permission bits are bit0 = read, bit1 = write, bit2 = execute. A matching access whose permission bit is clear returns a fault (code 2) with `rsp_paddr_o` = 0.
- R5: A permitted hit sets the slot's use bit. `rsp_first_o` is high on a hit only if that use bit was clear beforehand. A fault leaves the use bit unchanged.
- R6: A permitted write hit sets the slot's dirty bit. A faulting write does not.
- R7: A refill goes into the lowest-indexed invalid slot if one exists, otherwise into the least recently used slot. Only permitted hits and refills count as uses; misses and faults do not.
- R8: A refill sets the slot valid and clears its use and dirty bits.
- R9: When a refill evicts a valid dirty slot, `wb_valid_o` is high for exactly the following cycle, with the evicted slot's virtual and physical page numbers.
- R10: `flush_i` clears every valid bit in one cycle. A refill presented in the same cycle is dropped.
- R11: `req_ready_o` is low while `fill_valid_i` or `flush_i` is high. Each accepted request produces `rsp_valid_o` for exactly the next cycle.
- R12: After reset no slot is valid, and `rsp_valid_o` and `wb_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request can be accepted |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_res_o | output | 2 | Result: 0 hit, 1 miss, 2 fault |
| rsp_paddr_o | output | 32 | Translated address on hit, else 0 |
| rsp_first_o | output | 1 | Hit on a slot whose use bit was clear |
| fill_valid_i | input | 1 | Refill request |
| fill_vpn_i | input | 20 | Refill virtual page number |
| fill_ppn_i | input | 20 | Refill physical page number |
| fill_perm_i | input | 3 | Refill permissions: bit0 read, bit1 write, bit2 execute |
| flush_i | input | 1 | Invalidate all slots |
| wb_valid_o | output | 1 | A dirty slot was evicted |
| wb_vpn_o | output | 20 | Evicted virtual page number |
| wb_ppn_o | output | 20 | Evicted physical page number |

## Verification
The bench builds the block with its default parameters: 8 slots, a 32-bit address and a 12-bit page offset. With only 8 slots, a handful of refills after a flush fills the buffer, so replacement of the oldest slot, eviction of clean and dirty slots, and the fault path can all be reached in a few dozen cycles. The 20-bit page numbers let the bench use distinct page values and check every address bit that passes through.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } tlb_acc_e;

  typedef enum logic [1:0] {
    RES_HIT   = 2'd0,
    RES_MISS  = 2'd1,
    RES_FAULT = 2'd2
  } tlb_res_e;

  // permission vector bit positions
  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 8,
  parameter int VPN_W = 20
) (
  input  logic [N-1:0]            vld_i,
  input  logic [N-1:0][VPN_W-1:0] vpn_i,
  input  logic [VPN_W-1:0]        key_i,
  output logic                    hit_o,
  output logic [$clog2(N)-1:0]    idx_o
);
  localparam int IW = $clog2(N);

  logic [N-1:0] eq;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq[i] = vld_i[i] && (vpn_i[i] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) if (eq[i]) idx_o = IW'(i);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 touch_i,
  input  logic [$clog2(N)-1:0] touch_idx_i,
  input  logic [N-1:0]         vld_i,
  output logic [$clog2(N)-1:0] victim_o
);
  localparam int IW = $clog2(N);

  // age 0 = newest, N-1 = oldest; ages stay a permutation of 0..N-1
  logic [N-1:0][IW-1:0] age_q;

  for (genvar i = 0; i < N; i++) begin : g_age
    localparam logic [IW-1:0] IDX = IW'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[i] <= IDX;
      end else if (touch_i) begin
        if (touch_idx_i == IDX)                 age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  logic          free_found;
  logic [IW-1:0] free_idx, old_idx;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
    end
    old_idx = '0;
    for (int i = 0; i < N; i++) if (age_q[i] == IW'(N - 1)) old_idx = IW'(i);
  end

  assign victim_o = free_found ? free_idx : old_idx;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int N     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [VA_W-1:0]       req_vaddr_i,
  input  logic [1:0]            req_acc_i,
  output logic                  rsp_valid_o,
  output logic [1:0]            rsp_res_o,
  output logic [PA_W-1:0]       rsp_paddr_o,
  output logic                  rsp_first_o,
  input  logic                  fill_valid_i,
  input  logic [VA_W-OFF_W-1:0] fill_vpn_i,
  input  logic [PA_W-OFF_W-1:0] fill_ppn_i,
  input  logic [2:0]            fill_perm_i,
  input  logic                  flush_i,
  output logic                  wb_valid_o,
  output logic [VA_W-OFF_W-1:0] wb_vpn_o,
  output logic [PA_W-OFF_W-1:0] wb_ppn_o
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IW    = $clog2(N);

  logic [N-1:0]            vld_q, use_q, dirty_q;
  logic [N-1:0][VPN_W-1:0] vpn_q;
  logic [N-1:0][PPN_W-1:0] ppn_q;
  logic [N-1:0][2:0]       perm_q;

  logic          req_go, fill_go, hit, perm_ok, hit_ok;
  logic [IW-1:0] hit_idx, victim;

  assign req_ready_o = !fill_valid_i && !flush_i;
  assign req_go      = req_valid_i && req_ready_o;
  assign fill_go     = fill_valid_i && !flush_i;

  tlb_match #(.N(N), .VPN_W(VPN_W)) u_match (
    .vld_i (vld_q),
    .vpn_i (vpn_q),
    .key_i (req_vaddr_i[VA_W-1:OFF_W]),
    .hit_o (hit),
    .idx_o (hit_idx)
  );

  always_comb begin
    unique case (req_acc_i)
      ACC_READ:  perm_ok = perm_q[hit_idx][PERM_R];
      ACC_WRITE: perm_ok = perm_q[hit_idx][PERM_W];
      ACC_EXEC:  perm_ok = perm_q[hit_idx][PERM_X];
      default:   perm_ok = 1'b0;
    endcase
  end

  assign hit_ok = req_go && hit && perm_ok;

  tlb_lru #(.N(N)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (hit_ok || fill_go),
    .touch_idx_i (fill_go ? victim : hit_idx),
    .vld_i       (vld_q),
    .victim_o    (victim)
  );

  for (genvar i = 0; i < N; i++) begin : g_ent
    localparam logic [IW-1:0] IDX = IW'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i]   <= 1'b0;
        use_q[i]   <= 1'b0;
        dirty_q[i] <= 1'b0;
        vpn_q[i]   <= '0;
        ppn_q[i]   <= '0;
        perm_q[i]  <= '0;
      end else if (flush_i) begin
        vld_q[i]   <= 1'b0;
      end else if (fill_go && victim == IDX) begin
        vld_q[i]   <= 1'b1;
        use_q[i]   <= 1'b0;
        dirty_q[i] <= 1'b0;
        vpn_q[i]   <= fill_vpn_i;
        ppn_q[i]   <= fill_ppn_i;
        perm_q[i]  <= fill_perm_i;
      end else if (hit_ok && hit_idx == IDX) begin
        use_q[i]   <= 1'b1;
        if (req_acc_i == ACC_WRITE) dirty_q[i] <= 1'b1;
      end
    end
  end

  logic            rsp_valid_q, rsp_first_q, wb_valid_q;
  tlb_res_e        rsp_res_q;
  logic [PA_W-1:0] rsp_paddr_q;
  logic [VPN_W-1:0] wb_vpn_q;
  logic [PPN_W-1:0] wb_ppn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_res_q   <= RES_MISS;
      rsp_paddr_q <= '0;
      rsp_first_q <= 1'b0;
      wb_valid_q  <= 1'b0;
      wb_vpn_q    <= '0;
      wb_ppn_q    <= '0;
    end else begin
      rsp_valid_q <= req_go;
      if (req_go) begin
        rsp_res_q   <= !hit ? RES_MISS : (!perm_ok ? RES_FAULT : RES_HIT);
        rsp_paddr_q <= hit_ok ? {ppn_q[hit_idx], req_vaddr_i[OFF_W-1:0]} : '0;
        rsp_first_q <= hit_ok && !use_q[hit_idx];
      end else begin
        rsp_first_q <= 1'b0;
      end
      wb_valid_q <= fill_go && vld_q[victim] && dirty_q[victim];
      if (fill_go) begin
        wb_vpn_q <= vpn_q[victim];
        wb_ppn_q <= ppn_q[victim];
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_res_o   = rsp_res_q;
  assign rsp_paddr_o = rsp_paddr_q;
  assign rsp_first_o = rsp_first_q;
  assign wb_valid_o  = wb_valid_q;
  assign wb_vpn_o    = wb_vpn_q;
  assign wb_ppn_o    = wb_ppn_q;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_ready_o,
  input logic [VA_W-1:0]       req_vaddr_i,
  input logic                  rsp_valid_o,
  input logic [1:0]            rsp_res_o,
  input logic [PA_W-1:0]       rsp_paddr_o,
  input logic                  rsp_first_o,
  input logic                  fill_valid_i,
  input logic                  flush_i,
  input logic                  wb_valid_o
);
  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o); // R11
  AST_RSP_ONLY_ACCEPTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o); // R11
  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (rsp_res_o != 2'd0 ||
      rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0]))); // R1
  AST_NOHIT_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_res_o != 2'd0) |-> rsp_paddr_o == '0); // R3
  AST_RES_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_res_o != 2'd3); // R1
  AST_FIRST_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_first_o |-> (rsp_valid_o && rsp_res_o == 2'd0)); // R5
  AST_WB_AFTER_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(fill_valid_i && !flush_i)); // R9
  AST_FLUSH_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i ##1 (req_valid_i && req_ready_o) |=> rsp_res_o == 2'd1); // R10
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid, rsp_first;
  logic [1:0]  rsp_res;
  logic [31:0] rsp_paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [2:0]  fill_perm = '0;
  logic        flush = 1'b0;
  logic        wb_valid;
  logic [19:0] wb_vpn, wb_ppn;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  tlb_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr), .req_acc_i(req_acc),
    .rsp_valid_o(rsp_valid), .rsp_res_o(rsp_res), .rsp_paddr_o(rsp_paddr), .rsp_first_o(rsp_first),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn), .fill_perm_i(fill_perm),
    .flush_i(flush),
    .wb_valid_o(wb_valid), .wb_vpn_o(wb_vpn), .wb_ppn_o(wb_ppn)
  );

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;
  localparam logic [1:0] HIT = 2'd0, MISS = 2'd1, FLT = 2'd2;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic lookup(input string tag, input logic [31:0] va, input logic [1:0] acc,
                        input logic [1:0] e_res, input logic [31:0] e_pa, input logic e_first);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R11 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " result"}, 64'(rsp_res), 64'(e_res));
    chk({tag, " paddr"}, 64'(rsp_paddr), 64'(e_pa));
    chk({tag, " R5 first"}, 64'(rsp_first), 64'(e_first));
  endtask

  task automatic refill(input string tag, input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic [2:0] perm, input logic e_wb,
                        input logic [19:0] e_vpn, input logic [19:0] e_ppn);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_perm = perm; req_valid = 1'b1;
    #1 chk({tag, " R11 ready low in fill"}, 64'(req_ready), 64'd0);
    @(negedge clk);
    fill_valid = 1'b0; req_valid = 1'b0;
    chk({tag, " R11 no rsp for refused req"}, 64'(rsp_valid), 64'd0);
    chk({tag, " R9 wb_valid"}, 64'(wb_valid), 64'(e_wb));
    if (e_wb) begin
      chk({tag, " R9 wb_vpn"}, 64'(wb_vpn), 64'(e_vpn));
      chk({tag, " R9 wb_ppn"}, 64'(wb_ppn), 64'(e_ppn));
    end
  endtask

  task automatic do_flush(input logic with_fill, input logic [19:0] vpn);
    @(negedge clk);
    flush = 1'b1; fill_valid = with_fill; fill_vpn = vpn; fill_ppn = 20'h11111; fill_perm = 3'b111;
    #1 chk("R11 ready low in flush", 64'(req_ready), 64'd0);
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R12 wb_valid after reset", 64'(wb_valid), 64'd0);
    chk("R11 ready idle", 64'(req_ready), 64'd1);
    lookup("R12 R3 miss after reset", 32'h0001_0123, RD, MISS, 32'h0, 1'b0);
  endtask

  task automatic t_basic();
    refill("R8 fill A", 20'h00010, 20'h00ABC, 3'b011, 1'b0, '0, '0);
    lookup("R1 read hit A", 32'h0001_0123, RD, HIT, 32'h00AB_C123, 1'b1);
    @(negedge clk);
    chk("R11 rsp one cycle", 64'(rsp_valid), 64'd0);
    lookup("R5 second hit A", 32'h0001_0FFF, RD, HIT, 32'h00AB_CFFF, 1'b0);
    lookup("R4 exec fault A", 32'h0001_0004, EX, FLT, 32'h0, 1'b0);
    lookup("R1 write hit A", 32'h0001_0800, WR, HIT, 32'h00AB_C800, 1'b0);
    refill("R8 fill B", 20'h00020, 20'h00DEF, 3'b001, 1'b0, '0, '0);
    lookup("R4 write fault B", 32'h0002_0010, WR, FLT, 32'h0, 1'b0);
    lookup("R5 fault kept use clear B", 32'h0002_0010, RD, HIT, 32'h00DE_F010, 1'b1);
    lookup("R3 miss other page", 32'h0003_0000, RD, MISS, 32'h0, 1'b0);
  endtask

  task automatic t_flush();
    do_flush(1'b1, 20'h00030);
    lookup("R10 A gone", 32'h0001_0123, RD, MISS, 32'h0, 1'b0);
    lookup("R10 B gone", 32'h0002_0010, RD, MISS, 32'h0, 1'b0);
    lookup("R10 fill dropped", 32'h0003_0000, RD, MISS, 32'h0, 1'b0);
  endtask

  task automatic t_lru();
    for (int i = 0; i < 8; i++)
      refill("R7 fill free", 20'h00100 + 20'(i), 20'h00200 + 20'(i),
             (i == 3) ? 3'b001 : 3'b111, 1'b0, '0, '0);
    lookup("R8 R6 write hit 100", 32'h0010_0abc, WR, HIT, 32'h0020_0abc, 1'b1);
    lookup("R6 write fault 103", 32'h0010_3000, WR, FLT, 32'h0, 1'b0);
    refill("R7 evict 101 clean", 20'h00110, 20'h00310, 3'b111, 1'b0, '0, '0);
    lookup("R7 101 evicted", 32'h0010_1000, RD, MISS, 32'h0, 1'b0);
    lookup("R6 write hit 102", 32'h0010_2000, WR, HIT, 32'h0020_2000, 1'b1);
    refill("R6 evict 103 not dirty", 20'h00111, 20'h00311, 3'b111, 1'b0, '0, '0);
    for (int i = 4; i < 8; i++)
      lookup("R2 hit any slot", 32'h0010_0000 + (32'(i) << 12) + 32'h55, RD, HIT,
             32'h0020_0000 + (32'(i) << 12) + 32'h55, 1'b1);
    refill("R9 evict 100 dirty", 20'h00112, 20'h00312, 3'b111, 1'b1, 20'h00100, 20'h00200);
    @(negedge clk);
    chk("R9 wb one cycle", 64'(wb_valid), 64'd0);
    lookup("R7 100 evicted", 32'h0010_0000, RD, MISS, 32'h0, 1'b0);
    lookup("R7 103 evicted", 32'h0010_3000, RD, MISS, 32'h0, 1'b0);
    lookup("R8 new 112 fresh", 32'h0011_2abc, RD, HIT, 32'h0031_2abc, 1'b1);
    lookup("R2 hit 110", 32'h0011_0001, EX, HIT, 32'h0031_0001, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_flush();
    t_lru();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule